// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Capture

This block records when external events happen, measured against a shared 16-bit free-running count that arrives as an input. Each of three channels watches one input pin. A two-flop synchroniser brings each pin into the clock domain. A small per-channel state machine then follows the synchronised level and reports an edge when that level changes. If the channel's edge selection accepts that edge, the channel stores the current count in its capture register and raises its flag.

Software controls the block through a flat register space. It sets an edge selection for each channel, reads and clears the flags, and sets one interrupt enable per channel. A single interrupt line is raised while any channel has both its flag and its enable set.

Each channel's state machine has two states. `ST_LOW` means the last synchronised level was 0. `ST_HIGH` means it was 1. The machine moves from `ST_LOW` to `ST_HIGH` when the synchronised level reads 1 (a rising edge). It moves from `ST_HIGH` to `ST_LOW` when the level reads 0 (a falling edge). In every other case it stays where it is.

While a channel's capture is switched off, its synchronised pin level is presented on a plain input output.

Top module: `icap_top`

## Requirements
- R1: After reset, the edge-select register (address 0), the flag register (address 1) and the enable register (address 2) all read 0, and `irq` is low.
- R2: Channel k (k = 1..3) takes its edge selection from bits [2k-1:2k-2] of address 0. The codes are: 00 = capture off, 01 = rising edge only, 10 = falling edge only, 11 = either edge. An edge that the selection does not accept changes neither the flag nor the capture register.
- R3: After an accepted pin transition, the capture register holds the value `count` had in the cycle just before the third rising clock edge after the transition. Channels 1, 2 and 3 read their capture registers at addresses 3, 4 and 5.
- R4: An accepted edge sets the channel's flag. Flags for channels 1, 2 and 3 sit at bits 2, 1 and 0 of address 1.
- R5: Writing address 1 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R6: Capture registers ignore writes, and reset does not clear them.
- R7: Enables sit at address 2, at the same bit positions as the flags. `irq` is high exactly when some channel has both its flag and its enable set.
- R8: A new accepted edge overwrites the capture register even while the flag from an earlier capture is still set.
- R9: `gpio_out` bit k-1 shows channel k's synchronised pin level while its selection is 00, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | 16 | Shared free-running time base |
| pin_in | input | 3 | Event pins; bit k-1 belongs to channel k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational from rd_addr) |
| irq | output | 1 | Combined interrupt request |
| gpio_out | output | 3 | Synchronised pin levels for channels whose capture is off |

## Verification
A channel whose state machine lost track of the pin level would either take a false capture or miss a real one. That error shows in the flag bit and the capture value at the third clock edge after the transition. A fault in the flag set/clear logic shows on `irq` at once whenever the enable is set. A fault in the capture register's enable shows up as a changed timestamp after an ignored edge, a write attempt, or a reset pulse.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_t;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } chan_st_t;

    localparam int ADDR_SEL  = 0;
    localparam int ADDR_FLAG = 1;
    localparam int ADDR_MASK = 2;
    localparam int ADDR_CAP0 = 3;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/icap_chan.sv
module icap_chan
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  edge_sel_t        mode,
    input  logic [CNT_W-1:0] count,
    output logic             hit,
    output logic [CNT_W-1:0] stamp,
    output logic             gpio
);

    chan_st_t state_q;
    chan_st_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            ST_LOW: begin
                if (level) begin
                    state_d = ST_HIGH;
                    hit     = (mode == EDGE_RISE) || (mode == EDGE_ANY);
                end
            end
            ST_HIGH: begin
                if (!level) begin
                    state_d = ST_LOW;
                    hit     = (mode == EDGE_FALL) || (mode == EDGE_ANY);
                end
            end
        endcase
    end

    // timestamp: no reset, no software write path
    always_ff @(posedge clk) begin
        if (hit) begin
            stamp <= count;
        end
    end

    assign gpio = (mode == EDGE_OFF) ? level : 1'b0;

endmodule

// File: rtl/icap_regs.sv
module icap_regs
    import icap_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [NUM_CH-1:0]            hit,
    input  logic [NUM_CH-1:0][CNT_W-1:0] stamp,
    output logic [2*NUM_CH-1:0]          sel,
    output logic [NUM_CH-1:0]            flags,
    output logic [NUM_CH-1:0]            mask,
    output logic                         irq
);

    localparam int SEL_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;

    // channel index i maps to flag bit NUM_CH-1-i
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            set_v[NUM_CH-1-i] = hit[i];
        end
        clr_v = (wr_en && wr_addr == ADDR_W'(ADDR_FLAG)) ? wr_data[NUM_CH-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel   <= '0;
            flags <= '0;
            mask  <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(ADDR_SEL)) begin
                sel <= wr_data[SEL_W-1:0];
            end
            if (wr_en && wr_addr == ADDR_W'(ADDR_MASK)) begin
                mask <= wr_data[NUM_CH-1:0];
            end
            flags <= (flags & ~clr_v) | set_v;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_SEL)) begin
            rd_data[SEL_W-1:0] = sel;
        end
        if (rd_addr == ADDR_W'(ADDR_FLAG)) begin
            rd_data[NUM_CH-1:0] = flags;
        end
        if (rd_addr == ADDR_W'(ADDR_MASK)) begin
            rd_data[NUM_CH-1:0] = mask;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(ADDR_CAP0 + i)) begin
                rd_data[CNT_W-1:0] = stamp[i];
            end
        end
    end

    assign irq = |(flags & mask);

endmodule

// File: rtl/icap_top.sv
module icap_top
    import icap_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic [NUM_CH-1:0] gpio_out
);

    logic [NUM_CH-1:0]            level;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0][CNT_W-1:0] stamp;
    logic [2*NUM_CH-1:0]          sel;
    logic [NUM_CH-1:0]            flags;
    logic [NUM_CH-1:0]            mask;

    icap_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        icap_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .level (level[g]),
            .mode  (edge_sel_t'(sel[2*g +: 2])),
            .count (count),
            .hit   (hit[g]),
            .stamp (stamp[g]),
            .gpio  (gpio_out[g])
        );
    end

    icap_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .hit     (hit),
        .stamp   (stamp),
        .sel     (sel),
        .flags   (flags),
        .mask    (mask),
        .irq     (irq)
    );

endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [CNT_W-1:0]             count,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic [NUM_CH-1:0]            hit,
    input logic [NUM_CH-1:0][CNT_W-1:0] stamp,
    input logic [2*NUM_CH-1:0]          sel,
    input logic [NUM_CH-1:0]            flags
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam int FB = NUM_CH - 1 - i;

        AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2*i +: 2] == 2'b00) |-> !hit[i]); // R2

        AST_STAMP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> (stamp[i] == $past(count))); // R3

        AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flags[FB]); // R4

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(1) && wr_data[FB] && !hit[i]) |=> !flags[FB]); // R5

        AST_STAMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[i] |=> $stable(stamp[i])); // R6
    end

endmodule

bind icap_top icap_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (hit),
    .stamp   (stamp),
    .sel     (sel),
    .flags   (flags)
);

// File: tb/icap_top_bench.sv
module icap_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count = 16'h1000;
    logic [2:0]  pin_in = 3'b000;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [2:0]  gpio_out;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) count <= count + 16'd7;

    icap_top u_icap_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .pin_in   (pin_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq),
        .gpio_out (gpio_out)
    );

    // vector: {mode[1:0], start level, end level, capture expected}
    localparam logic [4:0] VEC [12] = '{
        5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_1_0,
        5'b11_0_1_1, 5'b11_1_0_1, 5'b00_0_1_0, 5'b00_1_0_0,
        5'b01_0_1_1, 5'b10_1_0_1, 5'b11_1_0_1, 5'b00_0_1_0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [15:0] data);
        rd_addr = 3'(addr);
        #1;
        data = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // toggle pin of channel c to lvl; return count seen by the capture
    task automatic drive_edge(input int c, input logic lvl, output logic [15:0] exp);
        @(negedge clk);
        pin_in[c] = lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        exp = count;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, exp, prev, e1, e2;

        idle(3);
        // R1 reset state
        rd(0, v); check("R1 sel", v, 16'h0);
        rd(1, v); check("R1 flags", v, 16'h0);
        rd(2, v); check("R1 mask", v, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // table walk: R2 R3 R4
        for (int k = 0; k < 12; k++) begin
            int c;
            logic [4:0] row;
            c   = k % 3;
            row = VEC[k];
            wr(0, 16'(row[4:3]) << (2*c));
            @(negedge clk);
            pin_in[c] = row[2];
            idle(4);
            wr(1, 16'h0007);
            idle(1);
            rd(3 + c, prev);
            drive_edge(c, row[1], exp);
            rd(1, v);
            check("R4 flag", {15'b0, v[2-c]}, {15'b0, row[0]});
            rd(3 + c, v);
            if (row[0]) check("R3 stamp", v, exp);
            else        check("R2 no capture", v, prev);
        end

        // R6 writes ignored
        rd(3, prev);
        wr(3, 16'hDEAD);
        rd(3, v); check("R6 write ignored", v, prev);

        // R8 overwrite while flag set, channel 2 any edge
        wr(0, 16'h000C);
        pin_in[1] = 1'b0;
        idle(4);
        wr(1, 16'h0007);
        drive_edge(1, 1'b1, e1);
        drive_edge(1, 1'b0, e2);
        rd(4, v); check("R8 overwrite", v, e2);
        rd(1, v); check("R8 flag kept", v, 16'h0002);

        // R5 selective clear: set channel 3 flag too
        wr(0, 16'h003C);
        pin_in[2] = 1'b0;
        idle(4);
        drive_edge(2, 1'b1, exp);
        rd(1, v); check("R5 two flags", v, 16'h0003);
        wr(1, 16'h0001);
        rd(1, v); check("R5 partial clear", v, 16'h0002);
        wr(1, 16'h0000);
        rd(1, v); check("R5 zero write", v, 16'h0002);

        // R7 interrupt combine
        wr(2, 16'h0004);
        check("R7 irq masked off", {15'b0, irq}, 16'h0);
        wr(2, 16'h0002);
        check("R7 irq on", {15'b0, irq}, 16'h1);
        wr(1, 16'h0002);
        check("R7 irq cleared", {15'b0, irq}, 16'h0);

        // R9 pin passthrough
        wr(0, 16'h0000);
        pin_in[0] = 1'b1;
        idle(3);
        check("R9 level shown", {15'b0, gpio_out[0]}, 16'h1);
        wr(0, 16'h0001);
        check("R9 level hidden", {15'b0, gpio_out[0]}, 16'h0);

        // R6 stamp survives reset
        rd(4, prev);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rd(4, v); check("R6 reset keeps stamp", v, prev);
        rd(1, v); check("R1 flags after reset", v, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule